// File: doc/BRIEF.md
# Edge-Qualified Interrupt Register Bank

This block watches five asynchronous status lines from a transceiver front end and turns their transitions into interrupts. Each status line has its own rising-edge enable bit and its own falling-edge enable bit. When a transition arrives and its enable bit is set, the block sets a sticky latch bit for that line. In the same cycle it drives a one-cycle event strobe. A downstream formatter uses that strobe to request a receive-command report. The interrupt output is high while any latch bit is set.

Software reaches the block through a byte-wide register bus that is plain and has no handshake. A write takes effect at the clock edge on which `bus_we` is high. Read data is a combinational function of `bus_addr`, and a read has no side effects. The status lines, the interrupt and the strobe are plain level or pulse pins. No stream interface exists here, so no back-pressure rules apply.

Each enable register answers at three consecutive addresses, and all three read back the same value. A write to the first address loads the register, a write to the second address sets bits, and a write to the third address clears bits. The latch has its own address, where a write clears every latch bit that is 1 in the data.

Top module: `edge_irq_regbank`

## Requirements
- R1: After reset, both enable registers read 1Fh at all of their addresses, the latch reads 00h, and `irq` and `evt_pulse` are 0.
- R2: The rising-edge enable register reads back at 0Dh, 0Eh and 0Fh. A write to 0Dh loads data bits 4..0, a write to 0Eh ORs them in, and a write to 0Fh clears the bits that are 1 in the data.
- R3: The falling-edge enable register behaves the same way at 10h (load), 11h (set) and 12h (clear), and reads back at all three addresses.
- R4: Bits 7..5 of every register read 0, and data written into those bits is discarded.
- R5: Status and enable bit n share one line. Bit 0 is host disconnect, bit 1 is VBUS valid, bit 2 is session valid, bit 3 is session end and bit 4 is ID ground. A 0-to-1 change on a status input whose rising enable bit is 1 behaves as follows. If the input changes before clock edge k, `evt_pulse` is high in the cycle after edge k+1, and latch bit n reads 1 after edge k+2.
- R6: A 1-to-0 change on a status input whose falling enable bit is 1 produces the same strobe and latch bit, with the same timing.
- R7: A transition whose matching enable bit is 0 leaves `evt_pulse` low and the latch unchanged.
- R8: The latch at 13h is sticky. A write to 13h clears only the latch bits that are 1 in the data. `irq` is 1 exactly while any latch bit is 1.
- R9: When a latch clear and an enabled edge on the same bit fall on the same clock edge, the latch bit ends up set.
- R10: Reads of addresses outside 0Dh..13h return 00h. Writes to those addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| status_in | input | 5 | Asynchronous status lines; bit 0 host disconnect, bit 1 VBUS valid, bit 2 session valid, bit 3 session end, bit 4 ID ground |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq | output | 1 | OR of all latch bits |
| evt_pulse | output | 1 | One-cycle strobe on any enabled edge |

## Verification
The hardest case to reach is the collision named in R9, where a latch clear write meets a freshly detected edge on the same clock edge. The two-stage synchronizer puts that edge two clock edges after the status input changes. The stimulus changes the status line, waits exactly two rising edges, and then raises the clear write so that the write lands on the third edge, where the latch captures the edge. The edge-enable behaviour is swept over every one of the 32 rise masks, with the fall mask set to the complement of the rise mask. The enable registers are swept over all 256 data bytes with each of the three write kinds.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int SRC_W_DEF  = 5;
  localparam int DATA_W_DEF = 8;
  localparam int ADDR_W_DEF = 8;

  typedef enum logic [1:0] {
    ENOP_NONE = 2'd0,
    ENOP_LOAD = 2'd1,
    ENOP_SET  = 2'd2,
    ENOP_CLR  = 2'd3
  } en_op_e;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/eirq_edge.sv
module eirq_edge #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  output logic [W-1:0] hits
);
  logic [W-1:0] prev_q;
  logic [W-1:0] went_up;
  logic [W-1:0] went_down;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  assign went_up   = cur & ~prev_q;
  assign went_down = ~cur & prev_q;
  assign hits      = (went_up & rise_en) | (went_down & fall_en);
endmodule

// File: rtl/eirq_enreg.sv
module eirq_enreg
  import eirq_pkg::*;
#(
  parameter int                W      = 5,
  parameter int                DATA_W = 8,
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE   = 8'h0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              sel,
  output logic [W-1:0]      en_q
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(3);

  logic [ADDR_W-1:0] off;
  en_op_e            op;
  logic [W-1:0]      dbits;

  assign off   = addr - BASE;
  assign sel   = (addr >= BASE) && (off < SPAN);
  assign dbits = wdata[W-1:0];

  always_comb begin
    op = ENOP_NONE;
    if (we && sel) begin
      unique case (off[1:0])
        2'd0:    op = ENOP_LOAD;
        2'd1:    op = ENOP_SET;
        default: op = ENOP_CLR;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '1;
    end else begin
      unique case (op)
        ENOP_LOAD: en_q <= dbits;
        ENOP_SET:  en_q <= en_q | dbits;
        ENOP_CLR:  en_q <= en_q & ~dbits;
        default:   en_q <= en_q;
      endcase
    end
  end
endmodule

// File: rtl/eirq_latch.sv
module eirq_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hits,
  input  logic         clr_valid,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] latch_q
);
  logic [W-1:0] kept;

  assign kept = clr_valid ? (latch_q & ~clr_mask) : latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else        latch_q <= kept | hits;
  end
endmodule

// File: rtl/edge_irq_regbank.sv
module edge_irq_regbank
  import eirq_pkg::*;
#(
  parameter int                SRC_W       = SRC_W_DEF,
  parameter int                DATA_W      = DATA_W_DEF,
  parameter int                ADDR_W      = ADDR_W_DEF,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] RISE_BASE   = 8'h0D,
  parameter logic [ADDR_W-1:0] FALL_BASE   = 8'h10,
  parameter logic [ADDR_W-1:0] LATCH_ADDR  = 8'h13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  status_in,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              evt_pulse
);
  logic [SRC_W-1:0] status_s;
  logic [SRC_W-1:0] rise_en;
  logic [SRC_W-1:0] fall_en;
  logic [SRC_W-1:0] hits;
  logic [SRC_W-1:0] latch_q;
  logic             rise_sel;
  logic             fall_sel;
  logic             latch_sel;

  eirq_sync #(.W(SRC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (status_in),
    .q     (status_s)
  );

  eirq_enreg #(.W(SRC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE(RISE_BASE)) u_rise (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .sel   (rise_sel),
    .en_q  (rise_en)
  );

  eirq_enreg #(.W(SRC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE(FALL_BASE)) u_fall (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .sel   (fall_sel),
    .en_q  (fall_en)
  );

  eirq_edge #(.W(SRC_W)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .cur     (status_s),
    .rise_en (rise_en),
    .fall_en (fall_en),
    .hits    (hits)
  );

  assign latch_sel = (bus_addr == LATCH_ADDR);

  eirq_latch #(.W(SRC_W)) u_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .hits      (hits),
    .clr_valid (bus_we && latch_sel),
    .clr_mask  (bus_wdata[SRC_W-1:0]),
    .latch_q   (latch_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (rise_sel)       bus_rdata[SRC_W-1:0] = rise_en;
    else if (fall_sel)  bus_rdata[SRC_W-1:0] = fall_en;
    else if (latch_sel) bus_rdata[SRC_W-1:0] = latch_q;
  end

  assign irq       = |latch_q;
  assign evt_pulse = |hits;
endmodule

// File: rtl/eirq_chk.sv
module eirq_chk #(
  parameter int                SRC_W      = 5,
  parameter int                DATA_W     = 8,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] RISE_BASE  = 8'h0D,
  parameter logic [ADDR_W-1:0] FALL_BASE  = 8'h10,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 8'h13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              evt_pulse,
  input logic [SRC_W-1:0]  rise_en,
  input logic [SRC_W-1:0]  fall_en
);
  logic outside;
  assign outside = (bus_addr < RISE_BASE) || (bus_addr > LATCH_ADDR);

  assert_rise_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == RISE_BASE) |=> (rise_en == $past(bus_wdata[SRC_W-1:0])));

  assert_fall_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == FALL_BASE + 1'b1) |=>
      (fall_en == ($past(fall_en) | $past(bus_wdata[SRC_W-1:0]))));

  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:SRC_W] == '0);

  assert_evt_sets_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |=> irq);

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(bus_we && bus_addr == LATCH_ADDR)) |=> irq);

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    outside |-> (bus_rdata == '0));

  assert_unmapped_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && outside) |=> ($stable(rise_en) && $stable(fall_en)));
endmodule

bind edge_irq_regbank eirq_chk #(
  .SRC_W(SRC_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .RISE_BASE(RISE_BASE), .FALL_BASE(FALL_BASE), .LATCH_ADDR(LATCH_ADDR)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .evt_pulse (evt_pulse),
  .rise_en   (rise_en),
  .fall_en   (fall_en)
);

// File: tb/sim_edge_irq_regbank.sv
`timescale 1ns/1ps
module sim_edge_irq_regbank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] status_in = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;
  logic       evt_pulse;

  int n_vec = 0;
  int n_bad = 0;
  logic [4:0] m_en [2];
  logic [4:0] m_latch;
  logic [4:0] m_stat;
  logic [7:0] base [2];

  always #4 clk = ~clk;

  edge_irq_regbank u0 (
    .clk(clk), .rst_n(rst_n), .status_in(status_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .evt_pulse(evt_pulse)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic check_en(input int r, input string req);
    logic [7:0] v;
    for (int k = 0; k < 3; k++) begin
      rd(base[r] + 8'(k), v);
      chk(req, v, {3'b000, m_en[r]});
    end
  endtask

  task automatic clear_latch();
    logic [7:0] v;
    wr(8'h13, 8'hFF);
    m_latch = '0;
    rd(8'h13, v);
    chk("R8 clear", v, 8'h00);
  endtask

  // change status, check strobe timing and resulting latch
  task automatic apply_stat(input logic [4:0] nv, input string req);
    logic [4:0] h;
    logic [7:0] v;
    h = (nv & ~m_stat & m_en[0]) | (~nv & m_stat & m_en[1]);
    @(negedge clk);
    status_in = nv;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk({req, " evt"}, {7'd0, evt_pulse}, {7'd0, |h});
    @(posedge clk);
    @(negedge clk);
    m_stat = nv;
    m_latch = m_latch | h;
    chk({req, " evt-end"}, {7'd0, evt_pulse}, 8'h00);
    rd(8'h13, v);
    chk({req, " latch"}, v, {3'b000, m_latch});
    chk("R8 irq", {7'd0, irq}, {7'd0, |m_latch});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    base[0] = 8'h0D; base[1] = 8'h10;
    m_en[0] = 5'h1F; m_en[1] = 5'h1F; m_latch = '0; m_stat = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 evt", {7'd0, evt_pulse}, 8'h00);
    rst_n = 1'b1;

    // R1/R10: read sweep of the low address space after reset
    for (int a = 0; a < 256; a++) begin
      logic [7:0] e;
      if (a >= 8'h0D && a <= 8'h12) e = 8'h1F;
      else e = 8'h00;
      rd(8'(a), v);
      chk((a >= 8'h0D && a <= 8'h13) ? "R1 reset value" : "R10 unmapped read", v, e);
    end

    // R2/R3/R4: every data byte through load, set and clear on both registers
    for (int r = 0; r < 2; r++) begin
      for (int d = 0; d < 256; d++) begin
        for (int op = 0; op < 3; op++) begin
          wr(base[r] + 8'(op), 8'(d));
          case (op)
            0: m_en[r] = 5'(d);
            1: m_en[r] = m_en[r] | 5'(d);
            default: m_en[r] = m_en[r] & ~5'(d);
          endcase
          check_en(r, (r == 0) ? "R2 rise reg R4" : "R3 fall reg R4");
        end
      end
    end

    // R10: writes to unmapped addresses leave the registers untouched
    wr(8'h0D, 8'h15); m_en[0] = 5'h15;
    wr(8'h10, 8'h0A); m_en[1] = 5'h0A;
    for (int a = 0; a < 256; a++) begin
      if (a < 8'h0D || a > 8'h13) begin
        wr(8'(a), (a % 2 == 0) ? 8'hFF : 8'h00);
        if (a % 16 == 0) begin
          check_en(0, "R10 unmapped write");
          check_en(1, "R10 unmapped write");
        end
      end
    end
    check_en(0, "R10 unmapped write");
    check_en(1, "R10 unmapped write");

    // R5/R6/R7: single-bit edges, each bit under all enable combinations
    for (int i = 0; i < 5; i++) begin
      for (int c = 0; c < 4; c++) begin
        m_en[0] = c[0] ? 5'h1F : ~(5'(1) << i);
        m_en[1] = c[1] ? 5'h1F : ~(5'(1) << i);
        wr(8'h0D, {3'b111, m_en[0]});
        wr(8'h10, {3'b111, m_en[1]});
        clear_latch();
        apply_stat(m_stat | (5'(1) << i), c[0] ? "R5 rise enabled" : "R7 rise disabled");
        clear_latch();
        apply_stat(m_stat & ~(5'(1) << i), c[1] ? "R6 fall enabled" : "R7 fall disabled");
      end
    end

    // R5/R6/R7: all bits toggling together over every rise mask
    for (int r = 0; r < 32; r++) begin
      m_en[0] = 5'(r);
      m_en[1] = ~5'(r);
      wr(8'h0D, 8'(r));
      wr(8'h10, {3'b000, m_en[1]});
      clear_latch();
      apply_stat(5'h1F, "R5 multi rise R7");
      apply_stat(5'h00, "R6 multi fall R7");
    end

    // R8: partial write-one-to-clear keeps the other bits and irq
    m_en[0] = 5'h1F; m_en[1] = 5'h1F;
    wr(8'h0D, 8'h1F); wr(8'h10, 8'h1F);
    clear_latch();
    apply_stat(5'h1F, "R8 fill");
    wr(8'h13, 8'hE5);
    rd(8'h13, v);
    chk("R8 partial clear", v, 8'h1A);
    chk("R8 irq held", {7'd0, irq}, 8'h01);
    wr(8'h13, 8'h1A);
    rd(8'h13, v);
    chk("R8 full clear", v, 8'h00);
    chk("R8 irq low", {7'd0, irq}, 8'h00);

    // R9: clear write lands on the same edge as an enabled fall on bit 2
    wr(8'h13, 8'h00);
    @(negedge clk);
    status_in = 5'h1B;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    chk("R9 evt", {7'd0, evt_pulse}, 8'h01);
    bus_addr = 8'h13; bus_wdata = 8'hFF; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    m_stat = 5'h1B;
    rd(8'h13, v);
    chk("R9 set beats clear", v, 8'h04);
    chk("R9 irq", {7'd0, irq}, 8'h01);

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule